// File: doc/BRIEF.md
# Firewall Exception Logger

This block sits beside an access-checking firewall. When the checker flags a blocked transaction, it pulses a one-cycle violation strobe. Along with the strobe it presents a reason code and the offending transaction's parameters: a 48-bit address, six attribute flags, a route identifier and a byte count. The logger stores these parameters in a small bank of 32-bit words and raises a pending line toward a security controller.

Software uses a simple word-indexed read/write port to service the violation. It reads the captured words, and reading the final data word drops the pending line automatically. A control word can disable capture and can mask the pending line, and each of these works independently of the other. Two further words let software force the pending state on or off, and reading either of them returns the current state.

While a violation is pending, the first captured record is frozen. Later violations keep the line asserted but never overwrite the record until software has serviced it.

Top module: `fwlog_top`

## Requirements
- R1: After reset the pending state and the control word are 0, `pendIrq` is low, and the code and data words read as 0. The register port uses combinational reads through `regRdata` for the index on `regSel`. Word indices are: 0 header0, 1 header1, 2 data0, 3 data1, 4 data2, 5 data3, 6 control, 7 pend-set, 8 pend-clear.
- R2: Word 0 always reads {8'h01, FW_ID[15:0], DEST_ID[7:0]}. Word 1 reads 8'h00 in bits 31:24, the captured code in bits 23:16, and zero elsewhere.
- R3: Word 2 returns the captured address bits 31:0. Word 3 returns captured address bits 47:32 in its bits 15:0.
- R4: Word 4 holds the captured flags in bits 8 to 13, in this order: secure (8), privileged (9), cacheable (10), debug (11), read (12), write (13). Word 4 also holds the route ID in bits 27:16. Word 5 holds the byte count in bits 9:0.
- R5: A violation strobe sets the pending state at the next clock edge, so `pendIrq` is high in the following cycle unless it is masked.
- R6: While the pending state is 1, a new violation leaves all captured words unchanged.
- R7: When control bit 0 is 1, a violation leaves the captured words unchanged but still sets the pending state.
- R8: When control bit 1 is 1, `pendIrq` is held low while the pending state stays readable. Clearing the bit exposes the pending state again.
- R9: A read (`regRd`) of word 5 clears the pending state at that clock edge.
- R10: Writing a value with bit 0 set to word 7 sets the pending state. Writing a value with bit 0 set to word 8 clears it. Writes with bit 0 clear have no effect. Reading word 7 or word 8 returns the pending state in bit 0.
- R11: If a set event (violation or pend-set write) and a clear event (word 5 read or pend-clear write) land on the same edge, the pending state ends up 1.
- R12: Writes to words 0 to 5 are ignored. Indices 9 to 15, and all bits not listed above, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vioValid | input | 1 | One-cycle violation strobe |
| vioCode | input | 8 | Violation reason code |
| vioAddr | input | 48 | Offending address |
| vioSecure | input | 1 | Secure attribute |
| vioPriv | input | 1 | Privileged attribute |
| vioCache | input | 1 | Cacheable attribute |
| vioDebug | input | 1 | Debug attribute |
| vioRead | input | 1 | Read attribute |
| vioWrite | input | 1 | Write attribute |
| vioRoute | input | 12 | Route identifier |
| vioBytes | input | 10 | Transaction byte count |
| regSel | input | 4 | Register word index |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects only) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regSel` |
| pendIrq | output | 1 | Pending notification to the security controller |

## Verification
The bench targets the collisions that a hand-written test tends to miss. One is a violation arriving on the same edge as the word-5 read or a pend-clear write. A design that lets the clear win would lose that violation silently. The bench also fires a second violation while one is still pending, which catches a design that overwrites the first record and leaves software to service the wrong event. It also checks that masking only hides the line and does not clear it, and that writes to the log indices and reads of unused indices leave no trace in the returned data.

// File: rtl/fwlog_pkg.sv
package fwlog_pkg;

  // Fixed field geometry of the log words
  localparam int SEL_W   = 4;
  localparam int ADDR_W  = 48;
  localparam int CODE_W  = 8;
  localparam int ROUTE_W = 12;
  localparam int CNT_W   = 10;
  localparam int ATTR_W  = 6;
  localparam int ADDR_HI = ADDR_W - 32;

  localparam logic [7:0] EXC_TYPE  = 8'h01;
  localparam logic [7:0] EXC_GROUP = 8'h00;

  // Word indices
  localparam logic [SEL_W-1:0] IDX_HDR0  = 4'd0;
  localparam logic [SEL_W-1:0] IDX_HDR1  = 4'd1;
  localparam logic [SEL_W-1:0] IDX_DATA0 = 4'd2;
  localparam logic [SEL_W-1:0] IDX_DATA1 = 4'd3;
  localparam logic [SEL_W-1:0] IDX_DATA2 = 4'd4;
  localparam logic [SEL_W-1:0] IDX_DATA3 = 4'd5;
  localparam logic [SEL_W-1:0] IDX_CTRL  = 4'd6;
  localparam logic [SEL_W-1:0] IDX_PSET  = 4'd7;
  localparam logic [SEL_W-1:0] IDX_PCLR  = 4'd8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // latch the violation record this edge
    logic pendStat;  // current pending state
    logic logOff;    // control bit 0
    logic maskOn;    // control bit 1
  } ctlStrobe_t;

endpackage

// File: rtl/fwlog_ctrl.sv
module fwlog_ctrl
  import fwlog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             vioValid,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [SEL_W-1:0] regSel,
  input  logic [1:0]       wrBits,
  output ctlStrobe_t       strb,
  output logic             pendIrq
);

  logic       pendQ;
  logic [1:0] ctrlQ;
  logic       wrCtrl, swSet, swClr, rdClr, setEv, clrEv;

  always_comb begin
    wrCtrl = regWr && (regSel == IDX_CTRL);
    swSet  = regWr && (regSel == IDX_PSET) && wrBits[0];
    swClr  = regWr && (regSel == IDX_PCLR) && wrBits[0];
    rdClr  = regRd && (regSel == IDX_DATA3);
    setEv  = vioValid || swSet;
    clrEv  = swClr || rdClr;
  end

  // Set has priority over clear so that no event is lost
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (setEv) begin
      pendQ <= 1'b1;
    end else if (clrEv) begin
      pendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrCtrl) begin
      ctrlQ <= wrBits;
    end
  end

  always_comb begin
    strb.capture  = vioValid && !ctrlQ[0] && !pendQ;
    strb.pendStat = pendQ;
    strb.logOff   = ctrlQ[0];
    strb.maskOn   = ctrlQ[1];
    pendIrq       = pendQ && !ctrlQ[1];
  end

endmodule

// File: rtl/fwlog_data.sv
module fwlog_data
  import fwlog_pkg::*;
#(
  parameter logic [15:0] FW_ID   = 16'h0123,
  parameter logic [7:0]  DEST_ID = 8'h05
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [CODE_W-1:0]  vioCode,
  input  logic [ADDR_W-1:0]  vioAddr,
  input  logic [ATTR_W-1:0]  vioAttr,
  input  logic [ROUTE_W-1:0] vioRoute,
  input  logic [CNT_W-1:0]   vioBytes,
  input  logic [SEL_W-1:0]   regSel,
  output logic [31:0]        regRdata,
  output logic [CODE_W-1:0]  logCodeQ
);

  logic [ADDR_W-1:0]  logAddr;
  logic [ATTR_W-1:0]  logAttr;
  logic [ROUTE_W-1:0] logRoute;
  logic [CNT_W-1:0]   logBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logCodeQ <= '0;
      logAddr  <= '0;
      logAttr  <= '0;
      logRoute <= '0;
      logBytes <= '0;
    end else if (strb.capture) begin
      logCodeQ <= vioCode;
      logAddr  <= vioAddr;
      logAttr  <= vioAttr;
      logRoute <= vioRoute;
      logBytes <= vioBytes;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      IDX_HDR0:  regRdata = {EXC_TYPE, FW_ID, DEST_ID};
      IDX_HDR1:  regRdata = {EXC_GROUP, logCodeQ, 16'h0000};
      IDX_DATA0: regRdata = logAddr[31:0];
      IDX_DATA1: regRdata[ADDR_HI-1:0] = logAddr[ADDR_W-1:32];
      IDX_DATA2: begin
        regRdata[8 +: ATTR_W]   = logAttr;
        regRdata[16 +: ROUTE_W] = logRoute;
      end
      IDX_DATA3: regRdata[CNT_W-1:0] = logBytes;
      IDX_CTRL:  regRdata[1:0] = {strb.maskOn, strb.logOff};
      IDX_PSET,
      IDX_PCLR:  regRdata[0] = strb.pendStat;
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/fwlog_top.sv
module fwlog_top
  import fwlog_pkg::*;
#(
  parameter logic [15:0] FW_ID   = 16'h0123,
  parameter logic [7:0]  DEST_ID = 8'h05
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vioValid,
  input  logic [7:0]  vioCode,
  input  logic [47:0] vioAddr,
  input  logic        vioSecure,
  input  logic        vioPriv,
  input  logic        vioCache,
  input  logic        vioDebug,
  input  logic        vioRead,
  input  logic        vioWrite,
  input  logic [11:0] vioRoute,
  input  logic [9:0]  vioBytes,
  input  logic [3:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        pendIrq
);

  ctlStrobe_t         strb;
  logic [CODE_W-1:0]  logCodeQ;
  logic [ATTR_W-1:0]  vioAttr;
  logic               unusedWdata;

  assign vioAttr     = {vioWrite, vioRead, vioDebug, vioCache, vioPriv, vioSecure};
  assign unusedWdata = ^regWdata[31:2];

  fwlog_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .vioValid (vioValid),
    .regWr    (regWr),
    .regRd    (regRd),
    .regSel   (regSel),
    .wrBits   (regWdata[1:0]),
    .strb     (strb),
    .pendIrq  (pendIrq)
  );

  fwlog_data #(
    .FW_ID   (FW_ID),
    .DEST_ID (DEST_ID)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .vioCode  (vioCode),
    .vioAddr  (vioAddr),
    .vioAttr  (vioAttr),
    .vioRoute (vioRoute),
    .vioBytes (vioBytes),
    .regSel   (regSel),
    .regRdata (regRdata),
    .logCodeQ (logCodeQ)
  );

endmodule

// File: rtl/fwlog_chk.sv
module fwlog_chk
  import fwlog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              vioValid,
  input logic              regWr,
  input logic              regRd,
  input logic [SEL_W-1:0]  regSel,
  input logic              wrBit0,
  input logic [31:0]       regRdata,
  input ctlStrobe_t        strb,
  input logic [CODE_W-1:0] logCodeQ
);

  // R5
  vio_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    vioValid |=> strb.pendStat);

  // R9
  rd_clears_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == IDX_DATA3 && !vioValid) |=> !strb.pendStat);

  // R6
  hold_log_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendStat |=> $stable(logCodeQ));

  // R7
  log_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.logOff |=> $stable(logCodeQ));

  // R10
  pset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == IDX_PSET && wrBit0) |=> strb.pendStat);

  // R12
  always_comb begin
    if (rstN && regSel > IDX_PCLR) begin
      unused_zero_chk: assert (regRdata == 32'h0);
    end
  end

endmodule

bind fwlog_top fwlog_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .vioValid (vioValid),
  .regWr    (regWr),
  .regRd    (regRd),
  .regSel   (regSel),
  .wrBit0   (regWdata[0]),
  .regRdata (regRdata),
  .strb     (strb),
  .logCodeQ (logCodeQ)
);

// File: tb/test_fwlog_top.sv
module test_fwlog_top;

  localparam logic [15:0] T_FW_ID   = 16'h0123;
  localparam logic [7:0]  T_DEST_ID = 8'h05;

  logic        clk = 1'b0;
  logic        rstN;
  logic        vioValid;
  logic [7:0]  vioCode;
  logic [47:0] vioAddr;
  logic        vioSecure, vioPriv, vioCache, vioDebug, vioRead, vioWrite;
  logic [11:0] vioRoute;
  logic [9:0]  vioBytes;
  logic [3:0]  regSel;
  logic        regWr, regRd;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        pendIrq;

  always #10 clk = ~clk;

  fwlog_top #(.FW_ID(T_FW_ID), .DEST_ID(T_DEST_ID)) i_fwlog_top (.*);

  // Reference model state
  bit        mPend;
  bit [1:0]  mCtrl;
  bit [7:0]  mCode;
  bit [47:0] mAddr;
  bit [5:0]  mAttr;
  bit [11:0] mRoute;
  bit [9:0]  mBytes;

  int checks = 0;
  int fails  = 0;

  function automatic logic [31:0] expRead(input logic [3:0] s);
    logic [31:0] v;
    v = 32'h0;
    case (s)
      4'd0: v = {8'h01, T_FW_ID, T_DEST_ID};
      4'd1: v = {8'h00, mCode, 16'h0};
      4'd2: v = mAddr[31:0];
      4'd3: v = {16'h0, mAddr[47:32]};
      4'd4: v = {4'h0, mRoute, 2'b00, mAttr, 8'h00};
      4'd5: v = {22'h0, mBytes};
      4'd6: v = {30'h0, mCtrl};
      4'd7, 4'd8: v = {31'h0, mPend};
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic modelStep();
    bit setEv, clrEv;
    if (!rstN) begin
      mPend = 0; mCtrl = 0; mCode = 0; mAddr = 0;
      mAttr = 0; mRoute = 0; mBytes = 0;
      return;
    end
    setEv = vioValid || (regWr && regSel == 4'd7 && regWdata[0]);
    clrEv = (regRd && regSel == 4'd5) || (regWr && regSel == 4'd8 && regWdata[0]);
    if (vioValid && !mCtrl[0] && !mPend) begin
      mCode  = vioCode;
      mAddr  = vioAddr;
      mAttr  = {vioWrite, vioRead, vioDebug, vioCache, vioPriv, vioSecure};
      mRoute = vioRoute;
      mBytes = vioBytes;
    end
    if (regWr && regSel == 4'd6) mCtrl = regWdata[1:0];
    if (setEv) mPend = 1;
    else if (clrEv) mPend = 0;
  endtask

  // One clock: compare outputs mid-cycle, advance model at the edge
  task automatic cyc(input string t);
    #1;
    check({t, " rdata"}, regRdata, expRead(regSel));
    check({t, " pendIrq"}, {31'h0, pendIrq}, {31'h0, (mPend && !mCtrl[1])});
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idleIn();
    vioValid = 0; regWr = 0; regRd = 0; regWdata = 32'h0;
  endtask

  task automatic rd(input logic [3:0] s, input string t);
    regSel = s; regRd = 1; cyc(t); idleIn();
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d, input string t);
    regSel = s; regWr = 1; regWdata = d; cyc(t); idleIn();
  endtask

  task automatic vio(input logic [7:0] c, input logic [47:0] a, input logic [5:0] at,
                     input logic [11:0] r, input logic [9:0] b, input string t);
    vioValid = 1; vioCode = c; vioAddr = a; vioRoute = r; vioBytes = b;
    {vioWrite, vioRead, vioDebug, vioCache, vioPriv, vioSecure} = at;
    cyc(t); idleIn();
  endtask

  task automatic look(input logic [3:0] s, input string t);
    regSel = s; cyc(t);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; regSel = 0; vioCode = 0; vioAddr = 0; vioRoute = 0; vioBytes = 0;
    {vioWrite, vioRead, vioDebug, vioCache, vioPriv, vioSecure} = 6'h0;
    idleIn();
    repeat (2) @(posedge clk);
    modelStep();
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 9; i++) look(4'(i), "R1 in reset");
    rstN = 1;
    for (int i = 0; i < 9; i++) look(4'(i), "R1 after reset");

    // R5 first violation raises the line
    vio(8'h04, 48'hABCD_1234_5678, 6'b101011, 12'hA5C, 10'h3FF, "R5");
    look(4'd7, "R5");
    look(4'd0, "R2 header0");
    look(4'd1, "R2 header1");
    look(4'd2, "R3 addr low");
    look(4'd3, "R3 addr high");
    look(4'd4, "R4 attrs");
    look(4'd5, "R4 bytes");

    // R6 second violation while pending
    vio(8'h07, 48'h0000_FFFF_0000, 6'b010100, 12'h001, 10'h010, "R6");
    look(4'd1, "R6"); look(4'd2, "R6"); look(4'd4, "R6");

    // R9 read of word 5 clears
    rd(4'd5, "R9");
    look(4'd7, "R9");

    // R3/R4 fresh capture after servicing
    vio(8'h08, 48'h8001_0000_0FFC, 6'b010101, 12'hFFF, 10'h004, "R3");
    look(4'd3, "R3"); look(4'd4, "R4"); look(4'd5, "R4");
    rd(4'd5, "R9");

    // R7 logging disabled
    wr(4'd6, 32'h1, "R7");
    vio(8'h06, 48'h1111_2222_3333, 6'b111111, 12'h321, 10'h055, "R7");
    look(4'd1, "R7"); look(4'd2, "R7"); look(4'd8, "R7"); look(4'd6, "R7");

    // R10 software set/clear
    wr(4'd8, 32'h1, "R10"); look(4'd7, "R10");
    wr(4'd7, 32'hFFFF_FFFE, "R10"); look(4'd7, "R10");
    wr(4'd7, 32'h1, "R10"); look(4'd8, "R10");
    wr(4'd8, 32'h0, "R10"); look(4'd8, "R10");
    wr(4'd8, 32'h1, "R10"); look(4'd7, "R10");

    // R8 masking hides but keeps the state
    wr(4'd6, 32'h2, "R8");
    vio(8'h05, 48'h0000_0000_1000, 6'b001000, 12'h0AA, 10'h100, "R8");
    look(4'd7, "R8"); look(4'd1, "R8");
    wr(4'd6, 32'h0, "R8"); look(4'd7, "R8");

    // R11 set and clear on the same edge
    vioValid = 1; vioCode = 8'h02; regSel = 4'd5; regRd = 1;
    cyc("R11 vio with data3 read"); idleIn();
    look(4'd8, "R11");
    vioValid = 1; vioCode = 8'h01; regSel = 4'd8; regWr = 1; regWdata = 32'h1;
    cyc("R11 vio with pend clear"); idleIn();
    look(4'd7, "R11"); look(4'd1, "R11");
    rd(4'd5, "R11");
    look(4'd7, "R11");

    // R12 log writes ignored, unused indices zero
    for (int i = 0; i < 6; i++) wr(4'(i), 32'hFFFF_FFFF, "R12");
    for (int i = 0; i < 6; i++) look(4'(i), "R12");
    wr(4'd6, 32'hFFFF_FFFC, "R12"); look(4'd6, "R12");
    for (int i = 9; i < 16; i++) look(4'(i), "R12");
    wr(4'd12, 32'hFFFF_FFFF, "R12"); look(4'd6, "R12"); look(4'd7, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule